// File: doc/BRIEF.md
# Immediate-Operand Integer Execute Unit

This block is the execute stage for immediate-format integer instructions in a 32-bit RISC pipeline. Each cycle it takes an already decoded operation code, the source register index and value, a 16-bit immediate, a 5-bit shift count, a rotate select and the destination index. One clock later it presents a registered result, a register-file write enable, an overflow trap flag and a reserved-instruction flag.

Each operation extends the immediate in its own way. Signed overflow is detected for the trapping add even when the destination is the zero register. The logical-right-shift code becomes a rotate when the select bit is set. A control module turns the operation code into a small bundle of strobes, and the datapath module applies them to the operands.

Top module: `imm_exec_unit`

## Requirements
- R1: Operation codes are 0 trapping add, 1 non-trapping add, 2 signed less-than, 3 unsigned less-than, 4 AND, 5 OR, 6 XOR, 7 upper-immediate load, 8 left shift, 9 logical right shift, 10 arithmetic right shift. For codes 0 to 3 the 16-bit immediate is sign-extended to 32 bits before use.
- R2: For AND, OR and XOR (codes 4 to 6) the immediate is zero-extended, so immediate bit 15 never reaches result bits 31:16.
- R3: Upper-immediate load (code 7) yields the immediate in bits 31:16 and zeros in bits 15:0, whatever the source value is.
- R4: A destination index of 0 never asserts the write enable. The trapping add still evaluates and raises its overflow flag with that destination.
- R5: The trapping add raises the overflow flag on signed two's-complement overflow and then keeps the write enable low. The non-trapping add never raises it and wraps modulo 2^32.
- R6: Signed less-than compares as two's-complement values and unsigned less-than compares as unsigned values, both against the sign-extended immediate. The result is 1 or 0 in bit 0 with bits 31:1 zero.
- R7: Left shift and logical right shift fill with zeros. Arithmetic right shift fills with copies of bit 31. The shift count covers 0 to 31, and a count of 0 returns the source unchanged.
- R8: Code 9 with the rotate select high rotates the source right by the shift count.
- R9: A source index of 0 makes the source operand zero, whatever value is on the source value input.
- R10: Codes 11 to 15 raise the reserved-instruction flag, keep the write enable low and never raise the overflow flag.
- R11: All outputs are registered, with a latency of one clock. A synchronous active-high reset clears the result and all flags. The result output is zero in every cycle where the write enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| opCode | input | 4 | Decoded operation code |
| srcIdx | input | 5 | Source register index (0 reads as zero) |
| srcVal | input | 32 | Source register value |
| immVal | input | 16 | Immediate field |
| shAmt | input | 5 | Shift count |
| rotSel | input | 1 | Turns logical right shift into rotate right |
| dstIdx | input | 5 | Destination register index |
| result | output | 32 | Registered result, zero when no write |
| regWrEn | output | 1 | Register-file write enable |
| ovfTrap | output | 1 | Overflow exception flag |
| rsvdInstr | output | 1 | Reserved-instruction flag |

## Verification
The bench builds the unit with its default parameters: a 32-bit data path, a 16-bit immediate and 5-bit register indices. With these values, immediate bit 15 sits exactly at the border between sign and zero extension. The carry into bit 31 decides overflow at the two extreme signed values. All 32 shift counts can be reached, including the 0 and 31 ends and a rotate that wraps the low bits to the top. Directed items cover these borders, and a randomized stream also drives the reserved codes and the zero source and destination indices.

// File: rtl/imm_exec_pkg.sv
package imm_exec_pkg;

  typedef enum logic [3:0] {
    OP_ADDT = 4'd0,
    OP_ADDU = 4'd1,
    OP_SLT  = 4'd2,
    OP_SLTU = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_LUI  = 4'd7,
    OP_SLL  = 4'd8,
    OP_SRL  = 4'd9,
    OP_SRA  = 4'd10
  } opCode_e;

  typedef enum logic [2:0] {
    UNIT_ADD,
    UNIT_CMP,
    UNIT_LOGIC,
    UNIT_UPPER,
    UNIT_SHIFT
  } unitSel_e;

  typedef enum logic [1:0] {
    LOG_AND,
    LOG_OR,
    LOG_XOR
  } logicOp_e;

  typedef enum logic [1:0] {
    SH_LEFT,
    SH_RIGHT_LOG,
    SH_RIGHT_ARITH,
    SH_ROTATE
  } shiftOp_e;

  // strobes handed from control to datapath
  typedef struct packed {
    unitSel_e unitSel;
    logic     signExt;
    logic     cmpUnsigned;
    logicOp_e logicOp;
    shiftOp_e shiftOp;
    logic     trapOnOvf;
    logic     reserved;
    logic     dstLive;
  } ctrlStrobe_t;

endpackage

// File: rtl/imm_exec_ctrl.sv
module imm_exec_ctrl
  import imm_exec_pkg::*;
#(
  parameter int REG_IDX_W = 5
) (
  input  logic [3:0]           opCode,
  input  logic                 rotSel,
  input  logic [REG_IDX_W-1:0] dstIdx,
  output ctrlStrobe_t          strobe
);

  always_comb begin
    strobe             = '0;
    strobe.unitSel     = UNIT_ADD;
    strobe.logicOp     = LOG_AND;
    strobe.shiftOp     = SH_LEFT;
    strobe.dstLive     = (dstIdx != '0);
    case (opCode)
      OP_ADDT: begin
        strobe.unitSel   = UNIT_ADD;
        strobe.signExt   = 1'b1;
        strobe.trapOnOvf = 1'b1;
      end
      OP_ADDU: begin
        strobe.unitSel = UNIT_ADD;
        strobe.signExt = 1'b1;
      end
      OP_SLT: begin
        strobe.unitSel = UNIT_CMP;
        strobe.signExt = 1'b1;
      end
      OP_SLTU: begin
        strobe.unitSel     = UNIT_CMP;
        strobe.signExt     = 1'b1;
        strobe.cmpUnsigned = 1'b1;
      end
      OP_AND: begin
        strobe.unitSel = UNIT_LOGIC;
        strobe.logicOp = LOG_AND;
      end
      OP_OR: begin
        strobe.unitSel = UNIT_LOGIC;
        strobe.logicOp = LOG_OR;
      end
      OP_XOR: begin
        strobe.unitSel = UNIT_LOGIC;
        strobe.logicOp = LOG_XOR;
      end
      OP_LUI: begin
        strobe.unitSel = UNIT_UPPER;
      end
      OP_SLL: begin
        strobe.unitSel = UNIT_SHIFT;
        strobe.shiftOp = SH_LEFT;
      end
      OP_SRL: begin
        strobe.unitSel = UNIT_SHIFT;
        strobe.shiftOp = rotSel ? SH_ROTATE : SH_RIGHT_LOG;
      end
      OP_SRA: begin
        strobe.unitSel = UNIT_SHIFT;
        strobe.shiftOp = SH_RIGHT_ARITH;
      end
      default: begin
        strobe.reserved = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/imm_exec_shifter.sv
module imm_exec_shifter
  import imm_exec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] shIn,
  input  logic [SH_W-1:0]   shCount,
  input  shiftOp_e          shiftOp,
  output logic [DATA_W-1:0] shOut
);

  logic                      isLeft;
  logic                      signBit;
  logic [DATA_W-1:0]         revIn;
  logic [DATA_W-1:0]         revOut;
  logic [SH_W:0][DATA_W-1:0] stage;

  assign isLeft  = (shiftOp == SH_LEFT);
  assign signBit = shIn[DATA_W-1];

  // a left shift is a right shift of the bit-reversed word
  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      revIn[i] = shIn[DATA_W-1-i];
    end
  end

  assign stage[0] = isLeft ? revIn : shIn;

  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    localparam int STEP = 1 << s;
    logic [STEP-1:0] fillBits;
    always_comb begin
      case (shiftOp)
        SH_ROTATE:      fillBits = stage[s][STEP-1:0];
        SH_RIGHT_ARITH: fillBits = {STEP{signBit}};
        default:        fillBits = '0;
      endcase
    end
    assign stage[s+1] = shCount[s] ? {fillBits, stage[s][DATA_W-1:STEP]} : stage[s];
  end

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      revOut[i] = stage[SH_W][DATA_W-1-i];
    end
  end

  assign shOut = isLeft ? revOut : stage[SH_W];

endmodule

// File: rtl/imm_exec_dp.sv
module imm_exec_dp
  import imm_exec_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int IMM_W     = 16,
  parameter int REG_IDX_W = 5,
  parameter int SH_W      = $clog2(DATA_W)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  ctrlStrobe_t          strobe,
  input  logic [REG_IDX_W-1:0] srcIdx,
  input  logic [DATA_W-1:0]    srcVal,
  input  logic [IMM_W-1:0]     immVal,
  input  logic [SH_W-1:0]      shAmt,
  output logic [DATA_W-1:0]    result,
  output logic                 regWrEn,
  output logic                 ovfTrap,
  output logic                 rsvdInstr
);

  localparam int EXT_W = DATA_W - IMM_W;
  localparam int MSB   = DATA_W - 1;

  logic [DATA_W-1:0] srcEff;
  logic [DATA_W-1:0] immExt;
  logic [DATA_W-1:0] sumVal;
  logic              ovfRaw;
  logic              ltFlag;
  logic [DATA_W-1:0] cmpVal;
  logic [DATA_W-1:0] logicVal;
  logic [DATA_W-1:0] upperVal;
  logic [DATA_W-1:0] shiftVal;
  logic [DATA_W-1:0] nextVal;
  logic              trapNow;
  logic              writeNow;

  assign srcEff = (srcIdx == '0) ? '0 : srcVal;
  assign immExt = strobe.signExt ? {{EXT_W{immVal[IMM_W-1]}}, immVal}
                                 : {{EXT_W{1'b0}}, immVal};

  // adder and signed overflow
  assign sumVal = srcEff + immExt;
  assign ovfRaw = (srcEff[MSB] == immExt[MSB]) && (sumVal[MSB] != srcEff[MSB]);

  // comparator
  assign ltFlag = strobe.cmpUnsigned ? (srcEff < immExt)
                                     : ($signed(srcEff) < $signed(immExt));
  assign cmpVal = {{(DATA_W-1){1'b0}}, ltFlag};

  // bitwise logic
  always_comb begin
    case (strobe.logicOp)
      LOG_OR:  logicVal = srcEff | immExt;
      LOG_XOR: logicVal = srcEff ^ immExt;
      default: logicVal = srcEff & immExt;
    endcase
  end

  assign upperVal = {immVal, {EXT_W{1'b0}}};

  imm_exec_shifter #(
    .DATA_W (DATA_W),
    .SH_W   (SH_W)
  ) shifter_i (
    .shIn    (srcEff),
    .shCount (shAmt),
    .shiftOp (strobe.shiftOp),
    .shOut   (shiftVal)
  );

  always_comb begin
    case (strobe.unitSel)
      UNIT_CMP:   nextVal = cmpVal;
      UNIT_LOGIC: nextVal = logicVal;
      UNIT_UPPER: nextVal = upperVal;
      UNIT_SHIFT: nextVal = shiftVal;
      default:    nextVal = sumVal;
    endcase
  end

  assign trapNow  = strobe.trapOnOvf && ovfRaw && !strobe.reserved;
  assign writeNow = strobe.dstLive && !strobe.reserved && !trapNow;

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      regWrEn   <= 1'b0;
      ovfTrap   <= 1'b0;
      rsvdInstr <= 1'b0;
    end else begin
      result    <= writeNow ? nextVal : '0;
      regWrEn   <= writeNow;
      ovfTrap   <= trapNow;
      rsvdInstr <= strobe.reserved;
    end
  end

endmodule

// File: rtl/imm_exec_unit.sv
module imm_exec_unit
  import imm_exec_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int IMM_W     = 16,
  parameter int REG_IDX_W = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [3:0]                  opCode,
  input  logic [REG_IDX_W-1:0]        srcIdx,
  input  logic [DATA_W-1:0]           srcVal,
  input  logic [IMM_W-1:0]            immVal,
  input  logic [$clog2(DATA_W)-1:0]   shAmt,
  input  logic                        rotSel,
  input  logic [REG_IDX_W-1:0]        dstIdx,
  output logic [DATA_W-1:0]           result,
  output logic                        regWrEn,
  output logic                        ovfTrap,
  output logic                        rsvdInstr
);

  localparam int SH_W = $clog2(DATA_W);

  ctrlStrobe_t strobe;

  imm_exec_ctrl #(
    .REG_IDX_W (REG_IDX_W)
  ) ctrl_i (
    .opCode (opCode),
    .rotSel (rotSel),
    .dstIdx (dstIdx),
    .strobe (strobe)
  );

  imm_exec_dp #(
    .DATA_W    (DATA_W),
    .IMM_W     (IMM_W),
    .REG_IDX_W (REG_IDX_W),
    .SH_W      (SH_W)
  ) dp_i (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .srcIdx    (srcIdx),
    .srcVal    (srcVal),
    .immVal    (immVal),
    .shAmt     (shAmt),
    .result    (result),
    .regWrEn   (regWrEn),
    .ovfTrap   (ovfTrap),
    .rsvdInstr (rsvdInstr)
  );

endmodule

// File: rtl/imm_exec_chk.sv
module imm_exec_chk
  import imm_exec_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int IMM_W     = 16,
  parameter int REG_IDX_W = 5
) (
  input logic                 clk,
  input logic                 rst,
  input logic [3:0]           opCode,
  input logic [IMM_W-1:0]     immVal,
  input logic [REG_IDX_W-1:0] dstIdx,
  input logic [DATA_W-1:0]    result,
  input logic                 regWrEn,
  input logic                 ovfTrap,
  input logic                 rsvdInstr
);

  AST_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    regWrEn |-> (!ovfTrap && !rsvdInstr)); // R5

  AST_DST_ZERO_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!rst && dstIdx == '0) |=> !regWrEn); // R4

  AST_UPPER_PLACE: assert property (@(posedge clk) disable iff (rst)
    (!rst && opCode == OP_LUI && dstIdx != '0) |=>
      (regWrEn && result[DATA_W-IMM_W-1:0] == '0 &&
       result[DATA_W-1:DATA_W-IMM_W] == $past(immVal))); // R3

  AST_ADDU_NO_TRAP: assert property (@(posedge clk) disable iff (rst)
    (!rst && opCode == OP_ADDU) |=> !ovfTrap); // R5

  AST_CMP_SINGLE_BIT: assert property (@(posedge clk) disable iff (rst)
    (!rst && (opCode == OP_SLT || opCode == OP_SLTU)) |=>
      (result[DATA_W-1:1] == '0)); // R6

  AST_RESERVED_FLAG: assert property (@(posedge clk) disable iff (rst)
    (!rst && opCode > OP_SRA) |=> (rsvdInstr && !regWrEn && !ovfTrap)); // R10

  AST_IDLE_RESULT: assert property (@(posedge clk) disable iff (rst)
    !regWrEn |-> (result == '0)); // R11

endmodule

bind imm_exec_unit imm_exec_chk #(
  .DATA_W    (DATA_W),
  .IMM_W     (IMM_W),
  .REG_IDX_W (REG_IDX_W)
) chk_i (.*);

// File: tb/imm_exec_unit_tb.sv
module imm_exec_unit_tb_top;

  typedef struct {
    logic [31:0] res;
    logic        wr;
    logic        ovf;
    logic        rsv;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  opCode = '0;
  logic [4:0]  srcIdx = '0;
  logic [31:0] srcVal = '0;
  logic [15:0] immVal = '0;
  logic [4:0]  shAmt = '0;
  logic        rotSel = 1'b0;
  logic [4:0]  dstIdx = '0;
  logic [31:0] result;
  logic        regWrEn;
  logic        ovfTrap;
  logic        rsvdInstr;

  int   errors = 0;
  int   checks = 0;
  exp_t expQ[$];

  always #5 clk = ~clk;

  imm_exec_unit #(
    .DATA_W    (32),
    .IMM_W     (16),
    .REG_IDX_W (5)
  ) dut_i (
    .clk       (clk),
    .rst       (rst),
    .opCode    (opCode),
    .srcIdx    (srcIdx),
    .srcVal    (srcVal),
    .immVal    (immVal),
    .shAmt     (shAmt),
    .rotSel    (rotSel),
    .dstIdx    (dstIdx),
    .result    (result),
    .regWrEn   (regWrEn),
    .ovfTrap   (ovfTrap),
    .rsvdInstr (rsvdInstr)
  );

  function automatic exp_t model(input logic [3:0] op, input logic [4:0] sIdx,
                                 input logic [31:0] src, input logic [15:0] imm,
                                 input logic [4:0] sh, input logic rot,
                                 input logic [4:0] dst);
    exp_t        e;
    logic [31:0] s;
    logic [31:0] sx;
    logic [31:0] zx;
    logic [31:0] v;
    longint      wide;
    logic        ovf;
    logic        rsv;
    s   = (sIdx == 5'd0) ? 32'd0 : src;
    sx  = {{16{imm[15]}}, imm};
    zx  = {16'd0, imm};
    v   = '0;
    ovf = 1'b0;
    rsv = 1'b0;
    case (op)
      4'd0: begin
        wide = longint'($signed(s)) + longint'($signed(sx));
        v    = s + sx;
        ovf  = (wide > 64'sd2147483647) || (wide < -64'sd2147483648);
      end
      4'd1:  v = s + sx;
      4'd2:  v = ($signed(s) < $signed(sx)) ? 32'd1 : 32'd0;
      4'd3:  v = (s < sx) ? 32'd1 : 32'd0;
      4'd4:  v = s & zx;
      4'd5:  v = s | zx;
      4'd6:  v = s ^ zx;
      4'd7:  v = {imm, 16'd0};
      4'd8:  v = s << sh;
      4'd9:  v = rot ? ((s >> sh) | (s << (6'd32 - {1'b0, sh}))) : (s >> sh);
      4'd10: v = $signed(s) >>> sh;
      default: rsv = 1'b1;
    endcase
    e.wr  = !rsv && !ovf && (dst != 5'd0);
    e.res = e.wr ? v : 32'd0;
    e.ovf = ovf;
    e.rsv = rsv;
    e.tag = "";
    return e;
  endfunction

  task automatic drive(input logic [3:0] op, input logic [4:0] sIdx,
                       input logic [31:0] src, input logic [15:0] imm,
                       input logic [4:0] sh, input logic rot,
                       input logic [4:0] dst, input string tag);
    exp_t e;
    @(negedge clk);
    opCode = op;
    srcIdx = sIdx;
    srcVal = src;
    immVal = imm;
    shAmt  = sh;
    rotSel = rot;
    dstIdx = dst;
    e      = model(op, sIdx, src, imm, sh, rot, dst);
    e.tag  = tag;
    expQ.push_back(e);
  endtask

  // monitor: results of the item driven before an edge appear after it
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        e = expQ.pop_front();
        checks++;
        if (result !== e.res || regWrEn !== e.wr || ovfTrap !== e.ovf || rsvdInstr !== e.rsv) begin
          errors++;
          $display("FAIL %s: got res=%h wr=%b ovf=%b rsv=%b expected res=%h wr=%b ovf=%b rsv=%b",
                   e.tag, result, regWrEn, ovfTrap, rsvdInstr, e.res, e.wr, e.ovf, e.rsv);
        end
      end
    end
  end

  task automatic check_reset(input string tag);
    checks++;
    if (result !== 32'd0 || regWrEn !== 1'b0 || ovfTrap !== 1'b0 || rsvdInstr !== 1'b0) begin
      errors++;
      $display("FAIL %s: reset got res=%h wr=%b ovf=%b rsv=%b expected all zero",
               tag, result, regWrEn, ovfTrap, rsvdInstr);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R11 reset clears outputs while a writing op is presented
    opCode = 4'd5; srcIdx = 5'd1; srcVal = 32'h1234_5678; immVal = 16'hFFFF; dstIdx = 5'd3;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset("R11");
    rst = 1'b0;

    // R5 trapping add overflow, positive and negative
    drive(4'd0, 5'd1, 32'h7FFF_FFFF, 16'h0001, 5'd0, 1'b0, 5'd2, "R5");
    drive(4'd0, 5'd1, 32'h8000_0000, 16'hFFFF, 5'd0, 1'b0, 5'd2, "R5");
    drive(4'd0, 5'd1, 32'h0000_0010, 16'hFFF0, 5'd0, 1'b0, 5'd2, "R1");
    // R4 zero destination: trap still seen, no write
    drive(4'd0, 5'd1, 32'h7FFF_FFFF, 16'h7FFF, 5'd0, 1'b0, 5'd0, "R4");
    drive(4'd0, 5'd1, 32'h0000_0001, 16'h0001, 5'd0, 1'b0, 5'd0, "R4");
    drive(4'd5, 5'd1, 32'h0000_00F0, 16'h000F, 5'd0, 1'b0, 5'd0, "R4");
    // R5 non-trapping add wraps
    drive(4'd1, 5'd1, 32'h7FFF_FFFF, 16'h0001, 5'd0, 1'b0, 5'd4, "R5");
    drive(4'd1, 5'd1, 32'h0000_0000, 16'h8000, 5'd0, 1'b0, 5'd4, "R1");
    // R6 comparisons
    drive(4'd2, 5'd1, 32'hFFFF_FFFF, 16'h0001, 5'd0, 1'b0, 5'd5, "R6");
    drive(4'd3, 5'd1, 32'hFFFF_FFFF, 16'h0001, 5'd0, 1'b0, 5'd5, "R6");
    drive(4'd3, 5'd1, 32'h0000_0005, 16'hFFFF, 5'd0, 1'b0, 5'd5, "R6");
    drive(4'd3, 5'd1, 32'hFFFF_FFFF, 16'hFFFF, 5'd0, 1'b0, 5'd5, "R6");
    // R2 zero extension
    drive(4'd4, 5'd1, 32'hFFFF_FFFF, 16'h8001, 5'd0, 1'b0, 5'd6, "R2");
    drive(4'd5, 5'd1, 32'h0F00_0000, 16'h8000, 5'd0, 1'b0, 5'd6, "R2");
    drive(4'd6, 5'd1, 32'hAAAA_AAAA, 16'hFFFF, 5'd0, 1'b0, 5'd6, "R2");
    // R3 upper immediate ignores source
    drive(4'd7, 5'd1, 32'hDEAD_BEEF, 16'hA5C3, 5'd0, 1'b0, 5'd7, "R3");
    // R9 source index zero reads as zero
    drive(4'd5, 5'd0, 32'hFFFF_0000, 16'h0011, 5'd0, 1'b0, 5'd8, "R9");
    drive(4'd10, 5'd0, 32'h8000_0000, 16'h0000, 5'd4, 1'b0, 5'd8, "R9");
    // R7 shifts at the count borders
    drive(4'd8, 5'd1, 32'h8000_0001, 16'h0000, 5'd0, 1'b0, 5'd9, "R7");
    drive(4'd8, 5'd1, 32'h0000_0003, 16'h0000, 5'd31, 1'b0, 5'd9, "R7");
    drive(4'd9, 5'd1, 32'h8000_0000, 16'h0000, 5'd31, 1'b0, 5'd9, "R7");
    drive(4'd10, 5'd1, 32'h8000_0000, 16'h0000, 5'd31, 1'b0, 5'd9, "R7");
    drive(4'd10, 5'd1, 32'h4000_0000, 16'h0000, 5'd3, 1'b0, 5'd9, "R7");
    // R8 rotate
    drive(4'd9, 5'd1, 32'h0000_00F1, 16'h0000, 5'd4, 1'b1, 5'd10, "R8");
    drive(4'd9, 5'd1, 32'h1234_5678, 16'h0000, 5'd0, 1'b1, 5'd10, "R8");
    drive(4'd9, 5'd1, 32'h0000_0001, 16'h0000, 5'd31, 1'b1, 5'd10, "R8");
    // rotate select has no effect on other shifts
    drive(4'd8, 5'd1, 32'h0000_00F1, 16'h0000, 5'd4, 1'b1, 5'd10, "R7");
    // R10 reserved codes
    drive(4'd11, 5'd1, 32'h7FFF_FFFF, 16'h0001, 5'd0, 1'b0, 5'd11, "R10");
    drive(4'd15, 5'd1, 32'h0000_0001, 16'h0001, 5'd0, 1'b0, 5'd11, "R10");

    // randomized stream
    for (int n = 0; n < 400; n++) begin
      drive(4'($urandom_range(0, 15)), 5'($urandom_range(0, 3)), $urandom,
            16'($urandom), 5'($urandom), 1'($urandom), 5'($urandom_range(0, 3)), "R1");
    end

    repeat (3) @(posedge clk);
    // R11 reset clears after activity
    @(negedge clk);
    opCode = 4'd1; srcIdx = 5'd1; srcVal = 32'h55; immVal = 16'h1; dstIdx = 5'd2;
    rst = 1'b1;
    @(negedge clk);
    check_reset("R11");
    rst = 1'b0;
    repeat (2) @(posedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule